// File: doc/BRIEF.md
# Register-Amount Shifter with Carry-Out

This block shifts or rotates a 32-bit word by an amount taken from a register operand and works out the carry flag that the operation produces. It is purely combinational. A shift type input picks one of four operations: logical left, logical right, arithmetic right or rotate right. The amount is the low byte of a 32-bit operand, so amounts from 0 to 255 occur, and each type has its own rules for amounts of zero, exactly the word width, and beyond it.

Next to the result the block gives a carry-out bit and a carry-valid bit. When carry-valid is low the flag register that consumes the carry must keep its old value. This happens exactly when the amount byte is zero. The block is meant to sit in an execute stage between the operand read and the flag update.

The block has no state. The house state-machine layout is kept only as naming and indentation. The amount is sorted into classes (zero, inside the word, exactly the width, beyond the width), and each shift type has a named branch of a single unique case that chooses the result and the carry.

Top module: `rcshift_carry`

## Requirements
- R1: The amount is bits [7:0] of `shift_opnd`. Bits [31:8] have no effect on any output.
- R2: When the amount is zero, `shift_result` equals `shift_value` and `carry_valid` is 0, for every shift type.
- R3: Logical left (`shift_kind`=0) by n in 1..31 gives `shift_value << n`, with carry equal to input bit 32-n.
- R4: Logical left by exactly 32 gives 0 with carry equal to input bit 0. Logical left by 33..255 gives 0 with carry 0.
- R5: Logical right (`shift_kind`=1) by n in 1..31 gives `shift_value >> n` with carry equal to input bit n-1. By exactly 32 it gives 0 with carry equal to bit 31. By 33..255 it gives 0 with carry 0.
- R6: Arithmetic right (`shift_kind`=2) by n in 1..31 fills from the left with bit 31 and gives carry equal to input bit n-1. By 32..255 every result bit equals input bit 31, and so does the carry.
- R7: Rotate right (`shift_kind`=3) rotates by the amount modulo 32. If that residue r is non-zero, the carry is input bit r-1. If r is 0 but the amount is not, the result equals the input and the carry is bit 31.
- R8: `carry_valid` is 1 whenever the amount byte is non-zero, for every shift type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_value | input | 32 | Word to be shifted or rotated |
| shift_opnd | input | 32 | Amount operand; only the low byte is used |
| shift_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| shift_result | output | 32 | Shifted or rotated word |
| carry_out | output | 1 | New carry flag value |
| carry_valid | output | 1 | High when the carry flag should take `carry_out` |

## Verification
The bench sweeps every type against all 256 amount bytes on several data words and compares each result with a 64-bit arithmetic model. This catches a design that reduces left and logical-right amounts modulo 32, which would give a non-zero result at 40 or 64. It also catches a design that takes the rotate carry from the 5-bit residue alone, which would drop the carry update at amounts 32, 64 or 224. The same sweep is repeated with junk in the operand's upper bits, which exposes a decoder that compares the full operand against 32. The width-exact cases also show up an off-by-one in the carry index, because the carry at 32 comes from bit 0 for left shifts and from bit 31 for right shifts.

// File: rtl/shc_pkg.sv
package shc_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic is_zero;   // amount byte is zero
        logic in_word;   // amount in 1..WIDTH-1
        logic is_width;  // amount exactly WIDTH
        logic low_zero;  // amount modulo WIDTH is zero
    } amt_class_t;

endpackage

// File: rtl/shc_amount_class.sv
module shc_amount_class #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic [AMT_W-1:0]      amt,
    output shc_pkg::amt_class_t   cls,
    output logic [LOG_W-1:0]      amt_low
);
    localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(WIDTH);

    logic hi_clear;

    always_comb begin
        amt_low      = amt[LOG_W-1:0];
        hi_clear     = (amt[AMT_W-1:LOG_W] == '0);
        cls.is_zero  = (amt == '0);
        cls.low_zero = (amt_low == '0);
        cls.in_word  = hi_clear && !cls.low_zero;
        cls.is_width = (amt == WIDTH_AMT);
    end
endmodule

// File: rtl/shc_barrel.sv
module shc_barrel #(
    parameter int WIDTH = 32,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]     din,
    input  logic [LOG_W-1:0]     amt,
    input  shc_pkg::shift_kind_e kind,
    output logic [WIDTH-1:0]     dout
);
    import shc_pkg::*;

    logic             go_left;
    logic             wrap;
    logic             fill;
    logic [WIDTH-1:0] din_rev;
    logic [WIDTH-1:0] core_out;
    logic [WIDTH-1:0] core_rev;
    logic [WIDTH-1:0] stage [LOG_W+1];

    assign go_left = (kind == SK_LSL);
    assign wrap    = (kind == SK_ROR);
    assign fill    = (kind == SK_ASR) ? din[WIDTH-1] : 1'b0;

    for (genvar b = 0; b < WIDTH; b++) begin : g_rev
        assign din_rev[b]  = din[WIDTH-1-b];
        assign core_rev[b] = core_out[WIDTH-1-b];
    end

    assign stage[0] = go_left ? din_rev : din;

    for (genvar s = 0; s < LOG_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [WIDTH-1:0] moved;
        always_comb begin
            if (wrap) begin
                moved = {stage[s][SH-1:0], stage[s][WIDTH-1:SH]};
            end else begin
                moved = {{SH{fill}}, stage[s][WIDTH-1:SH]};
            end
        end
        assign stage[s+1] = amt[s] ? moved : stage[s];
    end

    assign core_out = stage[LOG_W];
    assign dout     = go_left ? core_rev : core_out;
endmodule

// File: rtl/shc_carry_pick.sv
module shc_carry_pick #(
    parameter int WIDTH = 32,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]     din,
    input  logic [LOG_W-1:0]     amt,
    input  shc_pkg::shift_kind_e kind,
    output logic                 last_out
);
    import shc_pkg::*;

    logic [LOG_W-1:0] idx;

    always_comb begin
        idx = amt - LOG_W'(1);
        if (kind == SK_LSL) begin
            last_out = din[(WIDTH-1) - int'(idx)];
        end else begin
            last_out = din[idx];
        end
    end
endmodule

// File: rtl/rcshift_carry.sv
module rcshift_carry #(
    parameter int WIDTH  = 32,
    parameter int AMT_W  = 8,
    parameter int OPND_W = 32,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]  shift_value,
    input  logic [OPND_W-1:0] shift_opnd,
    input  logic [1:0]        shift_kind,
    output logic [WIDTH-1:0]  shift_result,
    output logic              carry_out,
    output logic              carry_valid
);
    import shc_pkg::*;

    shift_kind_e      kind;
    amt_class_t       cls;
    logic [LOG_W-1:0] amt_low;
    logic [WIDTH-1:0] shifted;
    logic             shifted_c;
    logic             sign_bit;
    logic             unused_opnd_hi;

    assign kind           = shift_kind_e'(shift_kind);
    assign sign_bit       = shift_value[WIDTH-1];
    assign unused_opnd_hi = ^shift_opnd[OPND_W-1:AMT_W];

    shc_amount_class #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_class (
        .amt     (shift_opnd[AMT_W-1:0]),
        .cls     (cls),
        .amt_low (amt_low)
    );

    shc_barrel #(.WIDTH(WIDTH)) u_barrel (
        .din  (shift_value),
        .amt  (amt_low),
        .kind (kind),
        .dout (shifted)
    );

    shc_carry_pick #(.WIDTH(WIDTH)) u_carry (
        .din      (shift_value),
        .amt      (amt_low),
        .kind     (kind),
        .last_out (shifted_c)
    );

    // Output selection: one branch per shift kind, amount class inside.
    always_comb begin
        shift_result = shift_value;
        carry_out    = 1'b0;
        carry_valid  = !cls.is_zero;
        if (!cls.is_zero) begin
            unique case (kind)
                SK_LSL: begin
                    if (cls.in_word) begin
                        shift_result = shifted;
                        carry_out    = shifted_c;
                    end else begin
                        shift_result = '0;
                        carry_out    = cls.is_width ? shift_value[0] : 1'b0;
                    end
                end
                SK_LSR: begin
                    if (cls.in_word) begin
                        shift_result = shifted;
                        carry_out    = shifted_c;
                    end else begin
                        shift_result = '0;
                        carry_out    = cls.is_width ? sign_bit : 1'b0;
                    end
                end
                SK_ASR: begin
                    if (cls.in_word) begin
                        shift_result = shifted;
                        carry_out    = shifted_c;
                    end else begin
                        shift_result = {WIDTH{sign_bit}};
                        carry_out    = sign_bit;
                    end
                end
                SK_ROR: begin
                    if (!cls.low_zero) begin
                        shift_result = shifted;
                        carry_out    = shifted_c;
                    end else begin
                        shift_result = shift_value;
                        carry_out    = sign_bit;
                    end
                end
                default: begin
                    shift_result = shift_value;
                    carry_out    = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
    parameter int WIDTH  = 32,
    parameter int AMT_W  = 8,
    parameter int OPND_W = 32
) (
    input logic [WIDTH-1:0]  shift_value,
    input logic [OPND_W-1:0] shift_opnd,
    input logic [1:0]        shift_kind,
    input logic [WIDTH-1:0]  shift_result,
    input logic              carry_out,
    input logic              carry_valid
);
    localparam int LOG_W = $clog2(WIDTH);
    localparam int AMT_MAX_W = AMT_W + 1;

    logic [AMT_W-1:0] amt;
    logic             unused_chk_hi;
    assign amt           = shift_opnd[AMT_W-1:0];
    assign unused_chk_hi = ^shift_opnd[OPND_W-1:AMT_W];

    always_comb begin
        // R2: zero amount holds the word and the flag
        if (amt == '0) begin
            p_zero_hold_r2: assert (shift_result == shift_value && !carry_valid)
                else $error("zero amount altered state");
        end
        // R8: non-zero amount always updates the flag
        if (amt != '0) begin
            p_flag_update_r8: assert (carry_valid)
                else $error("carry_valid low on non-zero amount");
        end
        // R4 / R5: logical shifts beyond the width clear everything
        if ((shift_kind == 2'd0 || shift_kind == 2'd1) &&
            AMT_MAX_W'(amt) > AMT_MAX_W'(WIDTH)) begin
            p_logic_flush_r4: assert (shift_result == '0 && !carry_out)
                else $error("over-width logical shift not flushed");
        end
        // R6: arithmetic right at or beyond the width is pure sign
        if (shift_kind == 2'd2 && AMT_MAX_W'(amt) >= AMT_MAX_W'(WIDTH)) begin
            p_sign_flood_r6: assert (
                    shift_result == {WIDTH{shift_value[WIDTH-1]}} &&
                    carry_out == shift_value[WIDTH-1])
                else $error("over-width arithmetic shift wrong");
        end
        // R7: rotate by a non-zero multiple of the width
        if (shift_kind == 2'd3 && amt != '0 && amt[LOG_W-1:0] == '0) begin
            p_rot_whole_r7: assert (
                    shift_result == shift_value &&
                    carry_out == shift_value[WIDTH-1])
                else $error("whole-turn rotate wrong");
        end
    end
endmodule

bind rcshift_carry shc_checker #(
    .WIDTH  (WIDTH),
    .AMT_W  (AMT_W),
    .OPND_W (OPND_W)
) u_shc_checker (
    .shift_value  (shift_value),
    .shift_opnd   (shift_opnd),
    .shift_kind   (shift_kind),
    .shift_result (shift_result),
    .carry_out    (carry_out),
    .carry_valid  (carry_valid)
);

// File: tb/test_rcshift_carry.sv
module test_rcshift_carry;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] shift_value = '0;
    logic [31:0] shift_opnd = '0;
    logic [1:0]  shift_kind = '0;
    logic [31:0] shift_result;
    logic        carry_out;
    logic        carry_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;   // 125 MHz

    rcshift_carry i_rcshift_carry (
        .shift_value  (shift_value),
        .shift_opnd   (shift_opnd),
        .shift_kind   (shift_kind),
        .shift_result (shift_result),
        .carry_out    (carry_out),
        .carry_valid  (carry_valid)
    );

    // Arithmetic reference built on 64-bit words
    task automatic model(input logic [31:0] v, input int kind, input int n,
                         output logic [31:0] r, output logic c, output logic cv);
        logic [63:0] t;
        logic signed [63:0] s;
        r  = v;
        c  = 1'b0;
        cv = (n != 0);
        if (n != 0) begin
            case (kind)
                0: begin
                    if (n <= 32) begin
                        t = {32'b0, v} << n;
                        r = t[31:0];
                        c = t[32];
                    end else begin
                        r = '0;
                        c = 1'b0;
                    end
                end
                1: begin
                    if (n <= 32) begin
                        t = {v, 32'b0} >> n;
                        r = t[63:32];
                        c = t[31];
                    end else begin
                        r = '0;
                        c = 1'b0;
                    end
                end
                2: begin
                    s = $signed({v, 32'b0}) >>> ((n > 32) ? 32 : n);
                    r = s[63:32];
                    c = s[31];
                end
                default: begin
                    t = {v, v} >> (n % 32);
                    r = t[31:0];
                    c = r[31];
                end
            endcase
        end
    endtask

    function automatic string tag_of(input int kind, input int n, input bit hi);
        if (hi) return "R1";
        if (n == 0) return "R2";
        case (kind)
            0: return (n < 32) ? "R3" : "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic apply_check(input logic [31:0] v, input logic [23:0] hi,
                               input int kind, input int n);
        logic [31:0] er;
        logic        ec, ecv;
        string       tg;
        @(posedge clk);
        shift_value = v;
        shift_opnd  = {hi, 8'(n)};
        shift_kind  = 2'(kind);
        @(negedge clk);
        model(v, kind, n, er, ec, ecv);
        tg = tag_of(kind, n, hi != '0);
        n_tests++;
        if (shift_result !== er || carry_out !== ec) begin
            n_fail++;
            $display("FAIL %s kind=%0d amt=%0d v=%h: got %h/%b expected %h/%b",
                     tg, kind, n, v, shift_result, carry_out, er, ec);
        end
        if (carry_valid !== ecv) begin
            n_fail++;
            $display("FAIL R8 kind=%0d amt=%0d: carry_valid got %b expected %b",
                     kind, n, carry_valid, ecv);
        end
    endtask

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'h1234_5678;
        pats[4] = 32'hC0DE_F00D;
        pats[5] = 32'h0000_0000;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state with all inputs zero (R2)
        @(negedge clk);
        n_tests++;
        if (shift_result !== 32'h0 || carry_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 idle: got %h/%b expected 00000000/0",
                     shift_result, carry_valid);
        end

        // Full sweep: all kinds, all amount bytes (R2..R8)
        for (int p = 0; p < 6; p++)
            for (int k = 0; k < 4; k++)
                for (int n = 0; n < 256; n++)
                    apply_check(pats[p], 24'h0, k, n);

        // Upper operand bits set: must not matter (R1)
        for (int p = 0; p < 3; p++)
            for (int k = 0; k < 4; k++)
                for (int n = 0; n < 256; n++)
                    apply_check(pats[p+2], 24'hA5C3F1 ^ 24'(n * 7), k, n);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected <= 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule